// File: doc/BRIEF.md
# I2S Master Serial Transmitter

This block is the output stage of a stereo playback path. It runs on a master audio clock and acts as clock master on an I2S link: it makes the bit clock by dividing the master clock by a programmable ratio, makes the word-select line, and shifts samples out MSB first in standard I2S timing. Bit clock and word select both use normal polarity.

Samples come from an external show-ahead FIFO that holds 32-bit words, one word per channel, with the left word before the right. The serializer pops one word at the start of each slot and sends only its low-order bits, up to the programmed sample width. When transmit is switched on, the link first carries one whole frame of silence and only then the queued samples. Whenever the FIFO has nothing ready at the start of a frame, that frame is sent as silence and the FIFO is left alone.

When transmit is switched off, the frame in flight is finished and the link then goes quiet. The register file, the FIFO and the codec are outside this block.

Top module: `i2s_master_tx`

## Requirements
- R1: While transmitting, each high phase and each low phase of `sck_o` lasts `ratio`+2 master clock cycles, so one bit clock period is 2*(`ratio`+2) cycles.
- R2: `ws_o` is low for the left slot and high for the right slot. It switches on the falling edge of `sck_o` that starts the last bit of the previous slot, so it leads each slot's MSB by one bit. `sd_o` and `ws_o` change only on falling edges of `sck_o`.
- R3: After `tx_en` rises from idle, the first frame (left slot, then right slot) is all zeros and pops nothing. Queued words follow from the second frame on.
- R4: A data slot carries bits W-1 down to 0 of its FIFO word, MSB first. Bits above W-1 are never sent.
- R5: The slot width W equals `res_cfg` when `res_cfg` is in the range 2 to 32, and 32 otherwise. Every slot is W bits long. W is taken from `res_cfg` at the start of each frame.
- R6: If `fifo_empty` is high when a left slot starts, the whole frame is zeros and the FIFO is not popped during that frame.
- R7: If the left word was popped but `fifo_empty` is high when the right slot starts, the right slot is zeros. `fifo_pop` is a one-cycle pulse that is raised only when `fifo_empty` was low in the cycle before. The FIFO must hold its head word stable until it sees the pop.
- R8: After `tx_en` is cleared, the current frame is completed. Then `sck_o`, `ws_o` and `sd_o` stay low until `tx_en` is set again, and a new start follows R3.
- R9: During and after synchronous reset, with `tx_en` low, `sck_o`, `ws_o`, `sd_o` and `fifo_pop` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmit enable |
| ratio | input | 8 | Bit clock divider setting; half period is ratio+2 cycles |
| res_cfg | input | 6 | Sample width in bits |
| fifo_data | input | 32 | Head word of the sample FIFO (show-ahead) |
| fifo_empty | input | 1 | FIFO has no word ready |
| fifo_pop | output | 1 | One-cycle pulse that removes the head word |
| sck_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select: low = left, high = right |
| sd_o | output | 1 | Serial data, MSB first |

## Verification
Some properties are checked on every cycle: the high phase of the bit clock lasts exactly ratio+2 cycles, data and word select move only on a falling bit-clock edge, and every pop is a single-cycle pulse issued against a non-empty FIFO. The other behaviours can only be seen across whole frames, so the bench scenarios show them. A receiver model in the bench rebuilds each slot and checks its contents, width, channel order, the leading zero frame, zero padding when the FIFO runs dry, and the frame-aligned stop when transmit is cleared.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

    localparam int DEF_WORD_W  = 32;
    localparam int DEF_RATIO_W = 8;
    localparam int DEF_RES_W   = 6;

    // channel slot; the encoding is the level driven on word select
    typedef enum logic {
        SIDE_L = 1'b0,
        SIDE_R = 1'b1
    } side_e;

    // word-select level for the bit after the current one
    function automatic logic next_ws(input side_e cur, input logic slot_ends);
        return slot_ends ? (cur == SIDE_L) : (cur == SIDE_R);
    endfunction

endpackage

// File: rtl/stx_bclk_gen.sv
module stx_bclk_gen #(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [RATIO_W-1:0] ratio,
    output logic               sck_o,
    output logic               fall_evt
);
    localparam int DIV_W = RATIO_W + 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] limit;
    logic             sck_q;
    logic             tick;

    assign limit    = {1'b0, ratio} + DIV_W'(1);
    assign tick     = run && (div_q >= limit);
    assign fall_evt = tick && sck_q;
    assign sck_o    = sck_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q <= '0;
            sck_q <= 1'b0;
        end else if (tick) begin
            div_q <= '0;
            sck_q <= ~sck_q;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/stx_framer.sv
module stx_framer
    import i2s_tx_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int RES_W  = 6,
    parameter int BIT_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic [RES_W-1:0]  res_cfg,
    input  logic [WORD_W-1:0] fifo_data,
    input  logic              fifo_empty,
    input  logic              fall_evt,
    output logic              run,
    output logic              fifo_pop,
    output logic              upd,
    output logic              load,
    output logic [WORD_W-1:0] load_word,
    output logic [BIT_W-1:0]  bit_idx,
    output logic              ws_nx
);
    localparam logic [RES_W-1:0] FULL_W = RES_W'(WORD_W);
    localparam logic [RES_W-1:0] ONE_W  = RES_W'(1);
    localparam logic [RES_W-1:0] TWO_W  = RES_W'(2);

    logic             run_q, run_d;
    side_e            side_q, side_d;
    logic [BIT_W-1:0] bitn_q, bitn_d;
    logic [RES_W-1:0] width_q, width_d;
    logic             live_q, live_d;
    logic             pop_q, take;
    logic [RES_W-1:0] w_cfg;
    logic [RES_W-1:0] idx_full;
    logic             slot_last;
    logic             start_evt;

    always_comb begin
        if (res_cfg < TWO_W || res_cfg > FULL_W) begin
            w_cfg = FULL_W;
        end else begin
            w_cfg = res_cfg;
        end
    end

    assign slot_last = (RES_W'(bitn_q) == width_q - ONE_W);
    assign start_evt = !run_q && tx_en;

    always_comb begin
        run_d     = run_q;
        side_d    = side_q;
        bitn_d    = bitn_q;
        width_d   = width_q;
        live_d    = live_q;
        take      = 1'b0;
        upd       = 1'b0;
        load      = 1'b0;
        load_word = '0;
        idx_full  = '0;
        ws_nx     = 1'b0;
        if (start_evt) begin
            // leading silent frame
            run_d    = 1'b1;
            side_d   = SIDE_L;
            bitn_d   = '0;
            width_d  = w_cfg;
            live_d   = 1'b0;
            upd      = 1'b1;
            load     = 1'b1;
            idx_full = w_cfg - ONE_W;
            ws_nx    = 1'b0;
        end else if (fall_evt) begin
            upd = 1'b1;
            if (slot_last && side_q == SIDE_R) begin
                side_d = SIDE_L;
                bitn_d = '0;
                load   = 1'b1;
                if (!tx_en) begin
                    run_d  = 1'b0;
                    live_d = 1'b0;
                    ws_nx  = 1'b0;
                end else begin
                    width_d   = w_cfg;
                    take      = !fifo_empty;
                    live_d    = !fifo_empty;
                    load_word = fifo_empty ? '0 : fifo_data;
                    idx_full  = w_cfg - ONE_W;
                    ws_nx     = 1'b0;
                end
            end else if (slot_last) begin
                take      = live_q && !fifo_empty;
                load      = 1'b1;
                load_word = (live_q && !fifo_empty) ? fifo_data : '0;
                idx_full  = width_q - ONE_W;
                side_d    = SIDE_R;
                bitn_d    = '0;
                ws_nx     = 1'b1;
            end else begin
                bitn_d   = bitn_q + BIT_W'(1);
                idx_full = width_q - TWO_W - RES_W'(bitn_q);
                ws_nx    = next_ws(side_q, RES_W'(bitn_q) == width_q - TWO_W);
            end
        end
    end

    assign bit_idx  = idx_full[BIT_W-1:0];
    assign run      = run_q;
    assign fifo_pop = pop_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q   <= 1'b0;
            side_q  <= SIDE_L;
            bitn_q  <= '0;
            width_q <= FULL_W;
            live_q  <= 1'b0;
            pop_q   <= 1'b0;
        end else begin
            run_q   <= run_d;
            side_q  <= side_d;
            bitn_q  <= bitn_d;
            width_q <= width_d;
            live_q  <= live_d;
            pop_q   <= take;
        end
    end
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter #(
    parameter int WORD_W = 32,
    parameter int BIT_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic [BIT_W-1:0]  bit_idx,
    input  logic              ws_nx,
    output logic              sd_o,
    output logic              ws_o
);
    logic [WORD_W-1:0] word_q;
    logic [WORD_W-1:0] src;
    logic              sd_q, ws_q;

    assign src  = load ? load_word : word_q;
    assign sd_o = sd_q;
    assign ws_o = ws_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            sd_q   <= 1'b0;
            ws_q   <= 1'b0;
        end else if (upd) begin
            if (load) begin
                word_q <= load_word;
            end
            sd_q <= src[bit_idx];
            ws_q <= ws_nx;
        end
    end
endmodule

// File: rtl/i2s_master_tx.sv
module i2s_master_tx
    import i2s_tx_pkg::*;
#(
    parameter int WORD_W  = DEF_WORD_W,
    parameter int RATIO_W = DEF_RATIO_W,
    parameter int RES_W   = DEF_RES_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tx_en,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [RES_W-1:0]   res_cfg,
    input  logic [WORD_W-1:0]  fifo_data,
    input  logic               fifo_empty,
    output logic               fifo_pop,
    output logic               sck_o,
    output logic               ws_o,
    output logic               sd_o
);
    localparam int BIT_W = $clog2(WORD_W);

    logic              run;
    logic              fall_evt;
    logic              upd;
    logic              load;
    logic [WORD_W-1:0] load_word;
    logic [BIT_W-1:0]  bit_idx;
    logic              ws_nx;

    stx_bclk_gen #(
        .RATIO_W(RATIO_W)
    ) u_bclk (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .ratio    (ratio),
        .sck_o    (sck_o),
        .fall_evt (fall_evt)
    );

    stx_framer #(
        .WORD_W(WORD_W),
        .RES_W (RES_W),
        .BIT_W (BIT_W)
    ) u_framer (
        .clk        (clk),
        .rst        (rst),
        .tx_en      (tx_en),
        .res_cfg    (res_cfg),
        .fifo_data  (fifo_data),
        .fifo_empty (fifo_empty),
        .fall_evt   (fall_evt),
        .run        (run),
        .fifo_pop   (fifo_pop),
        .upd        (upd),
        .load       (load),
        .load_word  (load_word),
        .bit_idx    (bit_idx),
        .ws_nx      (ws_nx)
    );

    stx_shifter #(
        .WORD_W(WORD_W),
        .BIT_W (BIT_W)
    ) u_shift (
        .clk       (clk),
        .rst       (rst),
        .upd       (upd),
        .load      (load),
        .load_word (load_word),
        .bit_idx   (bit_idx),
        .ws_nx     (ws_nx),
        .sd_o      (sd_o),
        .ws_o      (ws_o)
    );
endmodule

// File: rtl/i2s_master_tx_chk.sv
module i2s_master_tx_chk #(
    parameter int RATIO_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [RATIO_W-1:0] ratio,
    input logic               fifo_empty,
    input logic               fifo_pop,
    input logic               sck_o,
    input logic               ws_o,
    input logic               sd_o
);
    localparam int HC_W = RATIO_W + 2;

    logic [HC_W-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst || !sck_o) begin
            hi_cnt <= '0;
        end else begin
            hi_cnt <= hi_cnt + HC_W'(1);
        end
    end

    // R1: high phase of the bit clock lasts ratio+2 cycles
    a_r1_high_phase: assert property (@(posedge clk) disable iff (rst)
        $fell(sck_o) |-> hi_cnt == HC_W'(ratio) + HC_W'(2));

    // R2: word select moves only on a falling bit clock edge
    a_r2_ws_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(ws_o) |-> $fell(sck_o));

    // R2: serial data moves only on a falling bit clock edge
    a_r2_sd_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(sd_o) |-> $fell(sck_o));

    // R7: pop is a single-cycle pulse
    a_r7_pop_pulse: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> !fifo_pop);

    // R7: pop only follows a cycle with data present
    a_r7_pop_needs_data: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> $past(!fifo_empty));
endmodule

bind i2s_master_tx i2s_master_tx_chk #(
    .RATIO_W(RATIO_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ratio      (ratio),
    .fifo_empty (fifo_empty),
    .fifo_pop   (fifo_pop),
    .sck_o      (sck_o),
    .ws_o       (ws_o),
    .sd_o       (sd_o)
);

// File: tb/i2s_master_tx_tb.sv
`timescale 1ns/1ps
module i2s_master_tx_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_en = 1'b0;
    logic [7:0]  ratio = '0;
    logic [5:0]  res_cfg = 6'd32;
    logic [31:0] fifo_data;
    logic        fifo_empty;
    logic        fifo_pop;
    logic        sck_o, ws_o, sd_o;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    // show-ahead FIFO model
    logic [31:0] fmem [0:63];
    int wr_ptr = 0;
    int rd_ptr = 0;
    int pop_cnt = 0;
    assign fifo_empty = (rd_ptr == wr_ptr);
    assign fifo_data  = fmem[rd_ptr % 64];

    always @(posedge clk) begin
        if (fifo_pop) begin
            rd_ptr  <= rd_ptr + 1;
            pop_cnt <= pop_cnt + 1;
        end
    end

    i2s_master_tx u_dut (
        .clk        (clk),
        .rst        (rst),
        .tx_en      (tx_en),
        .ratio      (ratio),
        .res_cfg    (res_cfg),
        .fifo_data  (fifo_data),
        .fifo_empty (fifo_empty),
        .fifo_pop   (fifo_pop),
        .sck_o      (sck_o),
        .ws_o       (ws_o),
        .sd_o       (sd_o)
    );

    // receiver model: samples on rising bit clock edges
    logic [31:0] rx_word [0:1023];
    int          rx_bits [0:1023];
    logic        rx_side [0:1023];
    int          rx_n = 0;
    int          cyc_n = 0;
    int          last_rise = 0;
    int          last_period = 0;
    int          since_rise = 0;
    logic        sck_prev = 1'b0;
    logic        prev_ws = 1'b0;
    logic [31:0] acc = '0;
    int          bits = 0;

    always @(negedge clk) begin
        cyc_n = cyc_n + 1;
        since_rise = since_rise + 1;
        if (!sck_prev && sck_o) begin
            last_period = cyc_n - last_rise;
            last_rise = cyc_n;
            since_rise = 0;
            acc = {acc[30:0], sd_o};
            bits = bits + 1;
            if (ws_o != prev_ws) begin
                rx_word[rx_n % 1024] = acc;
                rx_bits[rx_n % 1024] = bits;
                rx_side[rx_n % 1024] = prev_ws;
                rx_n = rx_n + 1;
                acc = '0;
                bits = 0;
            end
            prev_ws = ws_o;
        end
        sck_prev = sck_o;
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_word(input int seed, input int i);
        return ((32'(seed) * 32'h9E3779B1) ^ (32'(i + 1) * 32'h85EBCA6B)) | 32'h8000_0101;
    endfunction

    function automatic int eff_w(input int rs);
        return (rs < 2 || rs > 32) ? 32 : rs;
    endfunction

    function automatic logic [31:0] mask_of(input int w);
        return 32'((64'd1 << w) - 64'd1);
    endfunction

    task automatic wait_quiet(input int rt);
        while (since_rise < 4 * (rt + 2) + 8) @(negedge clk);
    endtask

    // ratio[33:26] res[25:20] words[19:16] seed[15:0]
    localparam int NV = 7;
    localparam logic [33:0] VEC [0:NV-1] = '{
        {8'd0, 6'd32, 4'd4, 16'h0011},
        {8'd2, 6'd16, 4'd4, 16'h0022},
        {8'd1, 6'd24, 4'd3, 16'h0033},
        {8'd3, 6'd8,  4'd2, 16'h0044},
        {8'd0, 6'd0,  4'd2, 16'h0055},
        {8'd0, 6'd45, 4'd2, 16'h0066},
        {8'd4, 6'd12, 4'd5, 16'h0077}
    };

    task automatic run_vec(input int rt, input int rs, input int n, input int sd);
        int w;
        int start;
        int base;
        int want;
        int p0;
        logic [31:0] ew;
        w = eff_w(rs);
        @(negedge clk);
        ratio   = 8'(rt);
        res_cfg = 6'(rs);
        start   = wr_ptr;
        for (int i = 0; i < n; i++) begin
            fmem[(start + i) % 64] = mk_word(sd, i);
        end
        wr_ptr = start + n;
        base = rx_n;
        p0   = pop_cnt;
        want = 2 + 2 * ((n + 1) / 2) + 2;
        tx_en = 1'b1;
        while (rx_n - base < want) @(negedge clk);
        tx_en = 1'b0;
        wait_quiet(rt);
        for (int k = 0; k < want; k++) begin
            if (k < 2) ew = '0;
            else if (k - 2 < n) ew = fmem[(start + k - 2) % 64] & mask_of(w);
            else ew = '0;
            // R3 zero frame, R4 low bits MSB first, R7 right padding
            chk((k < 2) ? "R3 lead zero slot" : "R4/R7 slot data", rx_word[(base + k) % 1024], ew);
            chk("R5 slot width", rx_bits[(base + k) % 1024], w);
            chk("R2 slot side", rx_side[(base + k) % 1024], k % 2);
        end
        chk("R1 bit clock period", last_period, 2 * (rt + 2));
        chk("R3 pops match queued words", pop_cnt - p0, n);
        chk("R8 frame-aligned stop", (rx_n - base) % 2, 0);
        chk("R8 idle outputs", {sck_o, ws_o, sd_o}, 0);
    endtask

    task automatic empty_then_fill();
        int base;
        int p0;
        int j;
        int start;
        @(negedge clk);
        ratio   = 8'd1;
        res_cfg = 6'd16;
        base = rx_n;
        p0   = pop_cnt;
        tx_en = 1'b1;
        while (rx_n - base < 6) @(negedge clk);
        chk("R6 no pop while empty", pop_cnt - p0, 0);
        for (int k = 0; k < 6; k++) begin
            chk("R6 zero while empty", rx_word[(base + k) % 1024], 0);
        end
        start = wr_ptr;
        fmem[start % 64]       = mk_word(9, 0);
        fmem[(start + 1) % 64] = mk_word(9, 1);
        wr_ptr = start + 2;
        while (rx_n - base < 14) @(negedge clk);
        tx_en = 1'b0;
        wait_quiet(1);
        j = -1;
        for (int k = 6; k < rx_n - base; k++) begin
            if (j < 0 && rx_word[(base + k) % 1024] != 0) j = k;
        end
        chk("R6 data found after fill", (j >= 0) ? 1 : 0, 1);
        chk("R6 data starts on left slot", (j >= 0) ? (j % 2) : 1, 0);
        if (j >= 0) begin
            chk("R6 left word", rx_word[(base + j) % 1024], fmem[start % 64] & 32'h0000_FFFF);
            chk("R6 right word", rx_word[(base + j + 1) % 1024], fmem[(start + 1) % 64] & 32'h0000_FFFF);
        end
        chk("R6 pops after fill", pop_cnt - p0, 2);
        chk("R8 frame-aligned stop", (rx_n - base) % 2, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", total, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R9 reset outputs", {sck_o, ws_o, sd_o, fifo_pop}, 0);
        rst = 1'b0;
        repeat (40) @(negedge clk);
        chk("R9 quiet after reset", {sck_o, ws_o, sd_o, fifo_pop}, 0);
        chk("R9 no bit clock while disabled", rx_n + (since_rise < 40 ? 1 : 0), 0);
        for (int v = 0; v < NV; v++) begin
            run_vec(int'(VEC[v][33:26]), int'(VEC[v][25:20]), int'(VEC[v][19:16]), int'(VEC[v][15:0]));
        end
        empty_then_fill();
        repeat (20) @(negedge clk);
        chk("R8 stays idle", {sck_o, ws_o, sd_o}, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule